// File: doc/BRIEF.md
# Software-Managed TLB Access Unit

This block is a small set-associative translation lookaside buffer that software fills and inspects itself, through a plain control-register port. The port exposes three registers. The attribute word holds the frame number, the permission and cacheability flags, a global flag, and a software-only tag field. The page register holds the virtual page number. The control word holds the process identifier, a way index, a write-arm bit and a read-request bit. A write to the attribute word always updates it. When the write-arm bit is set, the same write also copies the attribute word, the page number and the process identifier into the entry chosen by the low page-number bits (the line) and the way index. The way index then steps forward, so consecutive writes fill consecutive ways. Setting the read-request bit pulls the selected entry back into all three registers.

The lookup side is a valid/ready stream. A request carries a virtual page number, a process identifier and an access kind. The response carries hit or miss, the frame number, the cacheable flag and a permission fault. A request is taken only when `lk_valid` and `lk_ready` are both high. A taken request yields a response one cycle later. A response that is not consumed (`rs_ready` low) stays on the pins unchanged, and `lk_ready` drops, so a stalled consumer applies back-pressure all the way to the requester.

Top module: `tlb_sw_unit`

## Requirements
- R1: After reset, every register reads zero and every entry is invalid, so each lookup misses.
- R2: The attribute word (sel 0) holds the software tag in bits 31:25, cacheable in bit 24, read-permit in bit 23, write-permit in bit 22, execute-permit in bit 21, global in bit 20 and the frame in bits 15:0. Bits 19:16 always read zero.
- R3: A write to sel 0 stores a TLB entry only while the write-arm bit (control word bit 10) is 1. With that bit at 0, the entries and the way index stay unchanged.
- R4: Each TLB write goes to line = page-register bits 3:0 and way = control-word bits 9:8. It then increments the way index, which wraps from 3 back to 0.
- R5: Writing control-word bit 11 as 1 sets it for one cycle. On the following edge, the selected entry's attribute word, page number and PID load into the three registers, and bit 11 reads 0 again.
- R6: An entry with global = 0 matches only when both the page number and the PID match. With global = 1, the PID is not compared.
- R7: The access kind is encoded as 0 = load (needs read-permit), 1 = store (needs write-permit), 2 = fetch (needs execute-permit) and 3 = reserved (never permitted). A hit without the needed permit sets the fault output. A miss never faults.
- R8: A hit returns the entry's frame and cacheable flag. A miss returns hit = 0, frame = 0, cacheable = 0 and fault = 0.
- R9: The response appears in the cycle after `lk_valid && lk_ready`. It stays stable while `rs_valid && !rs_ready`. `lk_ready` is `!rs_valid || rs_ready`.
- R10: The register selects are: sel 1 = page register (bits 19:0 = page number), sel 2 = control word (bits 7:0 = PID, 9:8 = way, 10 = write-arm, 11 = read-request). Sel 3 writes are ignored and sel 3 reads return zero. The read data is combinational on `csr_rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register written |
| csr_wdata | input | 32 | Register write data |
| csr_rd_sel | input | 2 | Register read back |
| csr_rdata | output | 32 | Register read data |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_pid | input | 8 | Process identifier of the request |
| lk_kind | input | 2 | Access kind (R7 encoding) |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Consumer takes the response |
| rs_hit | output | 1 | Entry matched |
| rs_fault | output | 1 | Permission fault |
| rs_frame | output | 16 | Physical frame number |
| rs_cacheable | output | 1 | Data access cacheable |

## Verification
The three kinds of result come due at different cycles:

- **Register writes:** these land on the edge that samples the strobe. Read-back is combinational, so the bench checks it at the falling edge after that write.
- **Read request:** the request bit shows for exactly one falling edge. The entry contents appear at the next falling edge, and the bench checks at both points.
- **Lookups:** the bench drives a lookup at a falling edge and judges the response at the following falling edge, one register later. The back-pressure case holds `rs_ready` low across two edges and checks that the first response is still present.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int DATA_W   = 32;
  localparam int TAG_LSB  = 25;
  localparam int C_BIT    = 24;
  localparam int R_BIT    = 23;
  localparam int W_BIT    = 22;
  localparam int X_BIT    = 21;
  localparam int G_BIT    = 20;
  localparam int WAY_LSB  = 8;
  localparam int ARM_BIT  = 10;
  localparam int RDQ_BIT  = 11;

  typedef enum logic [1:0] {
    SEL_ATTR = 2'd0,
    SEL_PAGE = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/tlb_csr.sv
module tlb_csr
  import tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int LINES   = 16,
  parameter int WAYS    = 4,
  parameter int FRAME_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     csr_wr_en,
  input  logic [1:0]               csr_sel,
  input  logic [DATA_W-1:0]        csr_wdata,
  input  logic [1:0]               csr_rd_sel,
  output logic [DATA_W-1:0]        csr_rdata,
  input  logic [DATA_W-1:0]        ent_attr,
  input  logic [VPN_W-1:0]         ent_vpn,
  input  logic [PID_W-1:0]         ent_pid,
  output logic                     wr_go,
  output logic [$clog2(LINES)-1:0] sel_line,
  output logic [$clog2(WAYS)-1:0]  sel_way,
  output logic [DATA_W-1:0]        wr_attr,
  output logic [VPN_W-1:0]         wr_vpn,
  output logic [PID_W-1:0]         wr_pid
);
  localparam int LINE_W = $clog2(LINES);
  localparam int WAY_W  = $clog2(WAYS);
  localparam logic [DATA_W-1:0] FLD_LOW   = (DATA_W'(1) << G_BIT) - DATA_W'(1);
  localparam logic [DATA_W-1:0] FRM_LOW   = (DATA_W'(1) << FRAME_W) - DATA_W'(1);
  localparam logic [DATA_W-1:0] ATTR_MASK = ~(FLD_LOW & ~FRM_LOW);

  logic [DATA_W-1:0] attr_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PID_W-1:0]  pid_q;
  logic [WAY_W-1:0]  way_q;
  logic              arm_q;
  logic              rdq_q;
  logic              wr_attr_sel, wr_page_sel, wr_ctrl_sel;
  logic [DATA_W-1:0] page_word, ctrl_word;

  assign wr_attr_sel = csr_wr_en && (csr_sel == SEL_ATTR);
  assign wr_page_sel = csr_wr_en && (csr_sel == SEL_PAGE);
  assign wr_ctrl_sel = csr_wr_en && (csr_sel == SEL_CTRL);

  assign wr_go    = wr_attr_sel && arm_q;
  assign wr_attr  = csr_wdata & ATTR_MASK;
  assign wr_vpn   = vpn_q;
  assign wr_pid   = pid_q;
  assign sel_line = vpn_q[LINE_W-1:0];
  assign sel_way  = way_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attr_q <= '0;
      vpn_q  <= '0;
      pid_q  <= '0;
      way_q  <= '0;
      arm_q  <= 1'b0;
      rdq_q  <= 1'b0;
    end else begin
      if (rdq_q) begin
        attr_q <= ent_attr;
        vpn_q  <= ent_vpn;
        pid_q  <= ent_pid;
        rdq_q  <= 1'b0;
      end
      if (wr_attr_sel) begin
        attr_q <= csr_wdata & ATTR_MASK;
        if (arm_q) way_q <= way_q + WAY_W'(1);
      end
      if (wr_page_sel) vpn_q <= csr_wdata[VPN_W-1:0];
      if (wr_ctrl_sel) begin
        pid_q <= csr_wdata[PID_W-1:0];
        way_q <= csr_wdata[WAY_LSB +: WAY_W];
        arm_q <= csr_wdata[ARM_BIT];
        rdq_q <= csr_wdata[RDQ_BIT];
      end
    end
  end

  always_comb begin
    page_word = '0;
    page_word[VPN_W-1:0] = vpn_q;
    ctrl_word = '0;
    ctrl_word[PID_W-1:0] = pid_q;
    ctrl_word[WAY_LSB +: WAY_W] = way_q;
    ctrl_word[ARM_BIT] = arm_q;
    ctrl_word[RDQ_BIT] = rdq_q;
    unique case (csr_rd_sel)
      SEL_ATTR: csr_rdata = attr_q;
      SEL_PAGE: csr_rdata = page_word;
      SEL_CTRL: csr_rdata = ctrl_word;
      default:  csr_rdata = '0;
    endcase
  end

  // R4
  way_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> way_q == WAY_W'($past(way_q) + WAY_W'(1)));
  // R3
  way_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_go && !wr_ctrl_sel) |=> $stable(way_q));
  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdq_q && !wr_ctrl_sel) |=> !rdq_q);
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int LINES   = 16,
  parameter int WAYS    = 4,
  parameter int FRAME_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_go,
  input  logic [$clog2(LINES)-1:0] sel_line,
  input  logic [$clog2(WAYS)-1:0]  sel_way,
  input  logic [DATA_W-1:0]        wr_attr,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [PID_W-1:0]         wr_pid,
  output logic [DATA_W-1:0]        ent_attr,
  output logic [VPN_W-1:0]         ent_vpn,
  output logic [PID_W-1:0]         ent_pid,
  input  logic [VPN_W-1:0]         lk_vpn,
  input  logic [PID_W-1:0]         lk_pid,
  output logic                     lk_hit,
  output logic [FRAME_W-1:0]       lk_frame,
  output logic                     lk_c,
  output logic                     lk_r,
  output logic                     lk_w,
  output logic                     lk_x
);
  localparam int LINE_W = $clog2(LINES);

  logic [DATA_W-1:0] attr_m [LINES][WAYS];
  logic [VPN_W-1:0]  vpn_m  [LINES][WAYS];
  logic [PID_W-1:0]  pid_m  [LINES][WAYS];
  logic [WAYS-1:0]   vld_m  [LINES];

  logic [LINE_W-1:0] lk_line;
  logic [WAYS-1:0]   way_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) begin
        vld_m[l] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          attr_m[l][w] <= '0;
          vpn_m[l][w]  <= '0;
          pid_m[l][w]  <= '0;
        end
      end
    end else if (wr_go) begin
      attr_m[sel_line][sel_way] <= wr_attr;
      vpn_m[sel_line][sel_way]  <= wr_vpn;
      pid_m[sel_line][sel_way]  <= wr_pid;
      vld_m[sel_line][sel_way]  <= 1'b1;
    end
  end

  assign ent_attr = attr_m[sel_line][sel_way];
  assign ent_vpn  = vpn_m[sel_line][sel_way];
  assign ent_pid  = pid_m[sel_line][sel_way];

  assign lk_line = lk_vpn[LINE_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic pid_ok;
    assign pid_ok = attr_m[lk_line][w][G_BIT] || (pid_m[lk_line][w] == lk_pid);
    assign way_match[w] = vld_m[lk_line][w] && (vpn_m[lk_line][w] == lk_vpn) && pid_ok;
  end

  always_comb begin
    logic [DATA_W-1:0] pick;
    pick = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_match[w]) pick = attr_m[lk_line][w];
    end
    lk_hit   = |way_match;
    lk_frame = pick[FRAME_W-1:0];
    lk_c     = pick[C_BIT];
    lk_r     = pick[R_BIT];
    lk_w     = pick[W_BIT];
    lk_x     = pick[X_BIT];
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> !lk_hit || $past(wr_go));
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               hit,
  input  logic [1:0]         kind,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               c_in,
  input  logic               r_in,
  input  logic               w_in,
  input  logic               x_in,
  output logic               fault,
  output logic [FRAME_W-1:0] frame_out,
  output logic               c_out
);
  logic permit;

  always_comb begin
    unique case (kind)
      KIND_LOAD:  permit = r_in;
      KIND_STORE: permit = w_in;
      KIND_FETCH: permit = x_in;
      default:    permit = 1'b0;
    endcase
  end

  assign fault     = hit && !permit;
  assign frame_out = hit ? frame_in : '0;
  assign c_out     = hit && c_in;
endmodule

// File: rtl/tlb_resp.sv
module tlb_resp #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic               hit,
  input  logic               fault,
  input  logic [FRAME_W-1:0] frame,
  input  logic               c,
  output logic               rs_valid,
  input  logic               rs_ready,
  output logic               rs_hit,
  output logic               rs_fault,
  output logic [FRAME_W-1:0] rs_frame,
  output logic               rs_cacheable
);
  assign lk_ready = !rs_valid || rs_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid     <= 1'b0;
      rs_hit       <= 1'b0;
      rs_fault     <= 1'b0;
      rs_frame     <= '0;
      rs_cacheable <= 1'b0;
    end else if (lk_ready) begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_hit       <= hit;
        rs_fault     <= fault;
        rs_frame     <= frame;
        rs_cacheable <= c;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> rs_valid && $stable(rs_frame) && $stable(rs_hit)
                                && $stable(rs_fault) && $stable(rs_cacheable));
  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_frame == '0) && !rs_fault && !rs_cacheable);
  // R7
  fault_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_fault) |-> rs_hit);
endmodule

// File: rtl/tlb_sw_unit.sv
module tlb_sw_unit
  import tlb_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int LINES   = 16,
  parameter int WAYS    = 4,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_wr_en,
  input  logic [1:0]         csr_sel,
  input  logic [31:0]        csr_wdata,
  input  logic [1:0]         csr_rd_sel,
  output logic [31:0]        csr_rdata,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [PID_W-1:0]   lk_pid,
  input  logic [1:0]         lk_kind,
  output logic               rs_valid,
  input  logic               rs_ready,
  output logic               rs_hit,
  output logic               rs_fault,
  output logic [FRAME_W-1:0] rs_frame,
  output logic               rs_cacheable
);
  localparam int LINE_W = $clog2(LINES);
  localparam int WAY_W  = $clog2(WAYS);

  logic              wr_go;
  logic [LINE_W-1:0] sel_line;
  logic [WAY_W-1:0]  sel_way;
  logic [DATA_W-1:0] wr_attr, ent_attr;
  logic [VPN_W-1:0]  wr_vpn, ent_vpn;
  logic [PID_W-1:0]  wr_pid, ent_pid;
  logic              a_hit, a_c, a_r, a_w, a_x;
  logic [FRAME_W-1:0] a_frame, p_frame;
  logic              p_fault, p_c;

  tlb_csr #(.VPN_W(VPN_W), .PID_W(PID_W), .LINES(LINES), .WAYS(WAYS), .FRAME_W(FRAME_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rd_sel(csr_rd_sel), .csr_rdata(csr_rdata),
    .ent_attr(ent_attr), .ent_vpn(ent_vpn), .ent_pid(ent_pid),
    .wr_go(wr_go), .sel_line(sel_line), .sel_way(sel_way),
    .wr_attr(wr_attr), .wr_vpn(wr_vpn), .wr_pid(wr_pid)
  );

  tlb_array #(.VPN_W(VPN_W), .PID_W(PID_W), .LINES(LINES), .WAYS(WAYS), .FRAME_W(FRAME_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .sel_line(sel_line), .sel_way(sel_way),
    .wr_attr(wr_attr), .wr_vpn(wr_vpn), .wr_pid(wr_pid),
    .ent_attr(ent_attr), .ent_vpn(ent_vpn), .ent_pid(ent_pid),
    .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_hit(a_hit), .lk_frame(a_frame),
    .lk_c(a_c), .lk_r(a_r), .lk_w(a_w), .lk_x(a_x)
  );

  tlb_perm #(.FRAME_W(FRAME_W)) u_perm (
    .hit(a_hit), .kind(lk_kind), .frame_in(a_frame), .c_in(a_c),
    .r_in(a_r), .w_in(a_w), .x_in(a_x),
    .fault(p_fault), .frame_out(p_frame), .c_out(p_c)
  );

  tlb_resp #(.FRAME_W(FRAME_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .hit(a_hit), .fault(p_fault), .frame(p_frame), .c(p_c),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit),
    .rs_fault(rs_fault), .rs_frame(rs_frame), .rs_cacheable(rs_cacheable)
  );
endmodule

// File: tb/sim_tlb_sw_unit.sv
module sim_tlb_sw_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic [1:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;
  logic [1:0]  csr_rd_sel = '0;
  logic [31:0] csr_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_pid = '0;
  logic [1:0]  lk_kind = '0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic        rs_hit, rs_fault, rs_cacheable;
  logic [15:0] rs_frame;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tlb_sw_unit u0 (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rd_sel(csr_rd_sel), .csr_rdata(csr_rdata),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
    .lk_kind(lk_kind), .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit),
    .rs_fault(rs_fault), .rs_frame(rs_frame), .rs_cacheable(rs_cacheable)
  );

  typedef struct packed {
    logic [19:0] vpn;
    logic [7:0]  pid;
    logic [1:0]  kind;
    logic        hit;
    logic        fault;
    logic [15:0] frame;
    logic        c;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{20'h00012, 8'h05, 2'd0, 1'b1, 1'b0, 16'hABCD, 1'b1},
    '{20'h00012, 8'h05, 2'd1, 1'b1, 1'b1, 16'hABCD, 1'b1},
    '{20'h00012, 8'h06, 2'd0, 1'b0, 1'b0, 16'h0000, 1'b0},
    '{20'h00022, 8'h77, 2'd2, 1'b1, 1'b0, 16'h1234, 1'b0},
    '{20'h00022, 8'h09, 2'd0, 1'b1, 1'b1, 16'h1234, 1'b0},
    '{20'h00032, 8'h05, 2'd1, 1'b1, 1'b0, 16'h0F0F, 1'b0},
    '{20'h00032, 8'h05, 2'd2, 1'b1, 1'b1, 16'h0F0F, 1'b0},
    '{20'h00042, 8'h05, 2'd2, 1'b1, 1'b0, 16'h7777, 1'b1},
    '{20'h00042, 8'h05, 2'd3, 1'b1, 1'b1, 16'h7777, 1'b1},
    '{20'h00052, 8'h05, 2'd0, 1'b0, 1'b0, 16'h0000, 1'b0},
    '{20'h00013, 8'h05, 2'd0, 1'b0, 1'b0, 16'h0000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_sel = s; csr_wdata = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] s, input string req, input logic [31:0] exp);
    csr_rd_sel = s;
    #1;
    chk(req, csr_rdata, exp);
  endtask

  task automatic lookup(input logic [19:0] v, input logic [7:0] p, input logic [1:0] k,
                        input string req, input logic h, input logic f,
                        input logic [15:0] fr, input logic c);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_pid = p; lk_kind = k; rs_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " valid"}, {31'd0, rs_valid}, 32'd1);
    chk({req, " hit/fault"}, {30'd0, rs_hit, rs_fault}, {30'd0, h, f});
    chk({req, " frame/c"}, {15'd0, rs_frame, rs_cacheable}, {15'd0, fr, c});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    csr_rd(2'd0, "R1 attr reset", 32'h0);
    csr_rd(2'd1, "R1 page reset", 32'h0);
    csr_rd(2'd2, "R1 ctrl reset", 32'h0);
    lookup(20'h0, 8'h0, 2'd0, "R1 empty lookup", 1'b0, 1'b0, 16'h0, 1'b0);

    // program four ways of line 2 (R4, R10)
    csr_wr(2'd2, 32'h0000_0405);
    csr_wr(2'd1, 32'h0000_0012);
    csr_wr(2'd0, 32'hAB80_ABCD);
    csr_rd(2'd2, "R4 way step", 32'h0000_0505);
    csr_rd(2'd0, "R2 attr kept", 32'hAB80_ABCD);
    csr_wr(2'd2, 32'h0000_0509);
    csr_wr(2'd1, 32'h0000_0022);
    csr_wr(2'd0, 32'h0030_1234);
    csr_wr(2'd2, 32'h0000_0605);
    csr_wr(2'd1, 32'h0000_0032);
    csr_wr(2'd0, 32'h00C0_0F0F);
    csr_wr(2'd1, 32'h0000_0042);
    csr_wr(2'd0, 32'h01E0_7777);
    csr_rd(2'd2, "R4 way wrap", 32'h0000_0405);
    csr_rd(2'd1, "R10 page readback", 32'h0000_0042);

    // R3 disarmed write, R2 masking, R10 sel 3
    csr_wr(2'd2, 32'h0000_0005);
    csr_wr(2'd1, 32'h0000_0052);
    csr_wr(2'd0, 32'hFFFF_FFFF);
    csr_rd(2'd0, "R2 frame gap zero", 32'hFFF0_FFFF);
    csr_rd(2'd2, "R3 way unchanged", 32'h0000_0005);
    csr_wr(2'd3, 32'hFFFF_FFFF);
    csr_rd(2'd3, "R10 sel3 zero", 32'h0);
    csr_rd(2'd1, "R10 sel3 ignored", 32'h0000_0052);

    // R5 read back way 1 of line 2
    csr_wr(2'd2, 32'h0000_0900);
    csr_rd(2'd2, "R5 request visible", 32'h0000_0900);
    @(negedge clk);
    csr_rd(2'd0, "R5 attr loaded", 32'h0030_1234);
    csr_rd(2'd1, "R5 page loaded", 32'h0000_0022);
    csr_rd(2'd2, "R5 pid loaded req clear", 32'h0000_0109);

    // table of lookups (R6 R7 R8 R3)
    for (int i = 0; i < NV; i++) begin
      lookup(VT[i].vpn, VT[i].pid, VT[i].kind, $sformatf("R6/R7/R8 vec%0d", i),
             VT[i].hit, VT[i].fault, VT[i].frame, VT[i].c);
    end

    // R9 back-pressure
    @(negedge clk);
    rs_ready = 1'b0; lk_valid = 1'b1; lk_vpn = 20'h00012; lk_pid = 8'h05; lk_kind = 2'd0;
    @(negedge clk);
    chk("R9 stalled ready low", {31'd0, lk_ready}, 32'd0);
    lk_vpn = 20'h00022;
    @(negedge clk);
    chk("R9 held frame", {16'd0, rs_frame}, 32'h0000_ABCD);
    chk("R9 held valid", {31'd0, rs_valid}, 32'd1);
    rs_ready = 1'b1;
    #1;
    chk("R9 ready follows consumer", {31'd0, lk_ready}, 32'd1);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R9 next frame", {16'd0, rs_frame}, 32'h0000_1234);
    @(negedge clk);
    chk("R9 drained", {31'd0, rs_valid}, 32'd0);

    // R1 reset mid-run invalidates entries
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    csr_rd(2'd2, "R1 ctrl after reset", 32'h0);
    lookup(20'h00012, 8'h05, 2'd0, "R1 flushed", 1'b0, 1'b0, 16'h0, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule